// File: doc/BRIEF.md
# Scaled Microfloat Vector Expander

This block widens packed low-precision floating-point vectors for a 32-lane wave into single, half or brain-float results. For each lane it also multiplies every element by a power-of-two factor. Each lane presents one packed source word together with a source-format code and a result-format code. Each lane also presents four unsigned 8-bit exponent scale bytes, each meaning 2^(e-127).

The factor a lane uses is not taken from its own scale bytes. One half of the wave, chosen by a common selector, holds the shared scale table. Lane L reads the entry of table lane L mod 16. The byte within that entry depends on the block-size setting, on a common byte selector, and on whether the lane sits in the lower or the upper sixteen lanes.

All 32 lanes are handled in parallel. Results appear one clock after an input strobe, together with an output strobe and a per-lane error flag. Illegal common settings and malformed per-lane requests raise that flag instead of producing data.

Top module: `mxfp_wave_expander`

## Requirements
- R1: Source format codes are 0 = fp4 E2M1, 1 = fp8 E4M3, 2 = fp8 E5M2, 3 = fp6 E2M3 and 4 = fp6 E3M2. Element k of a lane sits at bits [k*W +: W] of the lane's 96-bit source word, where W is 4, 8 or 6. The fp4 and fp8 formats carry 8 elements and the fp6 formats carry 16. Zero-exponent inputs are subnormal and are normalised before scaling.
- R2: Result format bits [1:0] select 0 = f32, 1 = f16 or 2 = bf16. Result element k of lane l occupies the 32-bit slot at out_data[(l*16+k)*32 +: 32]. Half-width results sit in the low 16 bits of the slot with the upper 16 bits zero. Slots 8 to 15 are zero for 8-element sources.
- R3: A lane raises its error flag and outputs all-zero slots in any of these cases: its source code is above 4, its result type is 3, or result-format bit 2 (1 = 16 elements) disagrees with the element count of its source.
- R4: With scl_half = 0, lane L takes its scale from the vector of lane L mod 16. With scl_half = 1, it takes it from lane 16 + (L mod 16).
- R5: With blk_size = 32, lanes 0-15 use byte scl_byte and lanes 16-31 use byte scl_byte+1. Byte b of a scale vector is bits [b*8 +: 8].
- R6: With blk_size = 16, lanes 0-15 use byte scl_byte and lanes 16-31 use byte scl_byte+2.
- R7: Only these common settings are legal: blk_size 16 with scl_byte 0 or 1, and blk_size 32 with scl_byte 0 or 2. Any other setting raises every lane's error flag and zeroes all data.
- R8: A scale byte e multiplies each element by 2^(e-127). A scale byte of 0xFF turns every element of that lane into a positive quiet NaN (0x7FC00000, 0x7E00 or 0x7FC0).
- R9: Signed zeros are passed through with their sign. E5M2 infinities stay signed infinities. The E5M2 NaN codes and the E4M3 pattern S.1111.111 become a quiet NaN. The fp4 and fp6 codes have no special values.
- R10: A scaled value above the result format's range becomes an infinity of the same sign.
- R11: A scaled value below the normal range becomes a subnormal or zero, and bits shifted out are truncated.
- R12: out_valid is high exactly one cycle after each cycle with in_valid high. Data and error flags are captured only on in_valid.
- R13: While reset is active, out_valid, out_err and out_data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe for the whole wave |
| blk_size | input | 6 | Block size, legal values 16 and 32 |
| scl_half | input | 1 | Wave half that holds the scale table |
| scl_byte | input | 2 | First scale byte selector |
| src_fmt | input | 96 | 3-bit source format code per lane |
| dst_fmt | input | 96 | 3-bit result format code per lane (bit 2 = 16 elements) |
| src_data | input | 3072 | 96-bit packed source word per lane |
| scl_vec | input | 1024 | Four scale bytes per lane |
| out_valid | output | 1 | Result strobe |
| out_err | output | 32 | Per-lane error flag |
| out_data | output | 16384 | Sixteen 32-bit result slots per lane |

## Verification
The scale-selection path is tried with a table in which every lane and byte holds a distinct exponent. A scaled 1.0 in f32 then shows in its exponent field which table lane and which byte each lane read. This separates the two half selectors, the two block sizes and both legal byte offsets. Fixed scale values are run through each source format to cover subnormal, signed-zero, infinity and NaN codes. A spread of per-lane scales on the half-width outputs pushes results into overflow, the exact normal range, subnormals and truncation down to one unit in the last place. Illegal settings and mismatched or unknown format codes confirm that errors zero the data and that only the offending lanes are flagged.

// File: rtl/mxfp_wave_expander.sv
module mxfp_wave_expander #(
  parameter int LANES = 32,
  parameter int SLOTS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [5:0]               blk_size,
  input  logic                     scl_half,
  input  logic [1:0]               scl_byte,
  input  logic [LANES*3-1:0]       src_fmt,
  input  logic [LANES*3-1:0]       dst_fmt,
  input  logic [LANES*SLOTS*6-1:0] src_data,
  input  logic [LANES*32-1:0]      scl_vec,
  output logic                     out_valid,
  output logic [LANES-1:0]         out_err,
  output logic [LANES*SLOTS*32-1:0] out_data
);
  localparam int HALF  = LANES / 2;
  localparam int HB    = $clog2(HALF);
  localparam int SRC_W = SLOTS * 6;

  typedef struct packed {
    logic       sgn;
    logic       zer;
    logic       inf;
    logic       nan;
    logic [9:0] ex;
    logic [2:0] fr;
  } elem_t;

  function automatic elem_t unpack_elem(input logic [2:0] f, input logic [7:0] r);
    elem_t d;
    logic [4:0] e;
    logic [2:0] mm;
    int bias, x;
    d = '0;
    case (f)
      3'd0: begin d.sgn = r[3]; e = {3'b0, r[2:1]}; mm = {r[0], 2'b0}; bias = 1; end
      3'd1: begin
        d.sgn = r[7]; e = {1'b0, r[6:3]}; mm = r[2:0]; bias = 7;
        d.nan = (r[6:0] == 7'h7F);
      end
      3'd2: begin
        d.sgn = r[7]; e = r[6:2]; mm = {r[1:0], 1'b0}; bias = 15;
        d.inf = (e == 5'h1F) && (mm == 3'd0);
        d.nan = (e == 5'h1F) && (mm != 3'd0);
      end
      3'd3: begin d.sgn = r[5]; e = {3'b0, r[4:3]}; mm = r[2:0]; bias = 1; end
      default: begin d.sgn = r[5]; e = {2'b0, r[4:2]}; mm = {r[1:0], 1'b0}; bias = 3; end
    endcase
    if (e != 5'd0) begin
      x = int'(e) - bias; d.fr = mm;
    end else if (mm[2]) begin
      x = -bias; d.fr = {mm[1:0], 1'b0};
    end else if (mm[1]) begin
      x = -bias - 1; d.fr = {mm[0], 2'b0};
    end else begin
      x = -bias - 2; d.fr = 3'd0; d.zer = (mm == 3'd0);
    end
    d.ex = 10'(x);
    return d;
  endfunction

  function automatic logic [31:0] pack_out(input logic [1:0] t, input elem_t d, input logic [7:0] sc);
    int fb, eb, bias, emax, be, sh;
    logic [31:0] sgn, sig;
    case (t)
      2'd1:    begin fb = 10; eb = 5; bias = 15;  end
      2'd2:    begin fb = 7;  eb = 8; bias = 127; end
      default: begin fb = 23; eb = 8; bias = 127; end
    endcase
    emax = (1 << eb) - 1;
    sgn  = 32'(d.sgn) << (eb + fb);
    if (sc == 8'hFF || d.nan) return (32'(emax) << fb) | (32'd1 << (fb - 1));
    if (d.inf) return sgn | (32'(emax) << fb);
    if (d.zer) return sgn;
    be = int'($signed(d.ex)) + int'(sc) - 127 + bias;
    if (be >= emax) return sgn | (32'(emax) << fb);
    if (be >= 1) return sgn | (32'(be) << fb) | (32'(d.fr) << (fb - 3));
    sh  = 1 - be;
    sig = {28'd0, 1'b1, d.fr} << (fb - 3);
    if (sh > 31) return sgn;
    return sgn | (sig >> sh);
  endfunction

  logic             cfg_bad;
  logic [LANES-1:0] lane_err;
  logic [31:0]      nd [LANES][SLOTS];

  assign cfg_bad = !((blk_size == 6'd16 && !scl_byte[1]) ||
                     (blk_size == 6'd32 && !scl_byte[0]));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int SRCL = g % HALF;
    logic [2:0]       sf, df;
    logic [SRC_W-1:0] w;
    logic [1:0]       bidx;
    logic [7:0]       sc;
    logic             six, four, bad;

    assign sf   = src_fmt[g*3 +: 3];
    assign df   = dst_fmt[g*3 +: 3];
    assign w    = src_data[g*SRC_W +: SRC_W];
    if (g < HALF) begin : g_lo
      assign bidx = scl_byte;
    end else begin : g_hi
      assign bidx = scl_byte + ((blk_size == 6'd32) ? 2'd1 : 2'd2);
    end
    assign sc   = scl_vec[{scl_half, HB'(SRCL), bidx, 3'b000} +: 8];
    assign six  = (sf == 3'd3) || (sf == 3'd4);
    assign four = (sf == 3'd0);
    assign bad  = cfg_bad || (sf > 3'd4) || (df[1:0] == 2'd3) || (df[2] != six);
    assign lane_err[g] = bad;

    for (genvar k = 0; k < SLOTS; k++) begin : g_el
      logic [7:0] raw;
      if (k < SLOTS / 2) begin : g_any
        assign raw = six ? {2'b0, w[k*6 +: 6]} : four ? {4'b0, w[k*4 +: 4]} : w[k*8 +: 8];
        assign nd[g][k] = bad ? 32'd0 : pack_out(df[1:0], unpack_elem(sf, raw), sc);
      end else begin : g_six
        assign raw = {2'b0, w[k*6 +: 6]};
        assign nd[g][k] = (bad || !six) ? 32'd0 : pack_out(df[1:0], unpack_elem(sf, raw), sc);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_err <= lane_err;
        for (int l = 0; l < LANES; l++)
          for (int k = 0; k < SLOTS; k++)
            out_data[(l*SLOTS+k)*32 +: 32] <= nd[l][k];
      end
    end
  end

  // R12
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R12
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R7
  cfg_err_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_bad) |=> (&out_err));
  // R3
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err[0]) |-> (out_data[SLOTS*32-1:0] == '0));
  // R8
  nan_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !lane_err[0] && g_lane[0].sc == 8'hFF) |=>
      (out_data[31:0] == 32'h7FC00000 || out_data[31:0] == 32'h00007E00 ||
       out_data[31:0] == 32'h00007FC0));
endmodule

// File: tb/mxfp_wave_expander_tb_top.sv
module mxfp_wave_expander_tb_top;
  localparam int L = 32;
  localparam int S = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [5:0]       blk_size = 6'd32;
  logic             scl_half = 1'b0;
  logic [1:0]       scl_byte = 2'd0;
  logic [L*3-1:0]   src_fmt = '0;
  logic [L*3-1:0]   dst_fmt = '0;
  logic [L*S*6-1:0] src_data = '0;
  logic [L*32-1:0]  scl_vec = '0;
  logic             out_valid;
  logic [L-1:0]     out_err;
  logic [L*S*32-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;

  mxfp_wave_expander dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .blk_size(blk_size),
    .scl_half(scl_half), .scl_byte(scl_byte), .src_fmt(src_fmt), .dst_fmt(dst_fmt),
    .src_data(src_data), .scl_vec(scl_vec), .out_valid(out_valid),
    .out_err(out_err), .out_data(out_data));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] slot(input int l, input int k);
    return out_data[(l*S+k)*32 +: 32];
  endfunction

  task automatic put(input int l, input logic [2:0] sf, input logic [2:0] df, input logic [95:0] w);
    src_fmt[l*3 +: 3] = sf;
    dst_fmt[l*3 +: 3] = df;
    src_data[l*96 +: 96] = w;
  endtask

  task automatic put_all(input logic [2:0] sf, input logic [2:0] df, input logic [95:0] w);
    for (int l = 0; l < L; l++) put(l, sf, df, w);
  endtask

  task automatic set_sc(input int l, input int b, input logic [7:0] v);
    scl_vec[l*32 + b*8 +: 8] = v;
  endtask

  task automatic fire();
    @(negedge clk) in_valid = 1'b1;
    @(negedge clk) in_valid = 1'b0;
  endtask

  task automatic cfg(input logic [5:0] bs, input logic h, input logic [1:0] b);
    blk_size = bs; scl_half = h; scl_byte = b;
  endtask

  task automatic t_reset();
    chk("R13 valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R13 err in reset", out_err, 32'd0);
    chk("R13 data in reset", {31'd0, |out_data}, 32'd0);
  endtask

  task automatic t_select(input logic [5:0] bs, input logic h, input logic [1:0] b);
    for (int l = 0; l < L; l++)
      for (int y = 0; y < 4; y++) set_sc(l, y, 8'(16 + l*4 + y));
    put_all(3'd1, 3'd0, 96'h38);
    cfg(bs, h, b);
    fire();
    for (int l = 0; l < L; l++) begin
      int sl, by;
      sl = h*16 + (l % 16);
      by = b + ((l >= 16) ? ((bs == 6'd32) ? 1 : 2) : 0);
      if (l < 16) chk("R4 R5 R6 low lane scale", slot(l, 0), 32'(16 + sl*4 + by) << 23);
      else if (bs == 6'd32) chk("R5 upper lane byte+1", slot(l, 0), 32'(16 + sl*4 + by) << 23);
      else chk("R6 upper lane byte+2", slot(l, 0), 32'(16 + sl*4 + by) << 23);
    end
    chk("R12 strobe after request", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    chk("R12 strobe drops", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_illegal(input logic [5:0] bs, input logic [1:0] b);
    scl_vec = {128{8'd127}};
    put_all(3'd1, 3'd0, 96'h38);
    cfg(bs, 1'b0, b);
    fire();
    chk("R7 all lanes flagged", out_err, 32'hFFFFFFFF);
    chk("R7 data zeroed", {31'd0, |out_data}, 32'd0);
    cfg(6'd32, 1'b0, 2'd0);
  endtask

  task automatic t_mismatch();
    scl_vec = {128{8'd127}};
    put_all(3'd1, 3'd0, 96'h38);
    put(5, 3'd1, 3'b100, 96'h38);
    put(6, 3'd5, 3'd0, 96'h38);
    put(7, 3'd3, 3'd0, 96'h38);
    put(8, 3'd1, 3'd3, 96'h38);
    fire();
    chk("R3 flagged lanes", out_err, 32'h1E0);
    chk("R3 bad lane zero", slot(5, 0), 32'd0);
    chk("R3 good lane data", slot(4, 0), 32'h3F800000);
  endtask

  task automatic t_fp4();
    scl_vec = {128{8'd127}};
    put_all(3'd0, 3'd0, 96'h0008_0F12);
    fire();
    chk("R1 fp4 1.0", slot(0, 0), 32'h3F800000);
    chk("R1 fp4 subnormal", slot(0, 1), 32'h3F000000);
    chk("R1 fp4 -6", slot(0, 2), 32'hC0C00000);
    chk("R9 fp4 zero", slot(0, 3), 32'h0);
    chk("R9 fp4 -0", slot(0, 4), 32'h80000000);
    chk("R2 upper slot zero", slot(0, 8), 32'h0);
  endtask

  task automatic t_fp8();
    scl_vec = {128{8'd127}};
    put_all(3'd2, 3'd0, 96'hFC01_7D7C);
    fire();
    chk("R9 e5m2 inf", slot(1, 0), 32'h7F800000);
    chk("R9 e5m2 nan", slot(1, 1), 32'h7FC00000);
    chk("R1 e5m2 subnormal", slot(1, 2), 32'h37800000);
    chk("R9 e5m2 -inf", slot(1, 3), 32'hFF800000);
    put_all(3'd1, 3'd0, 96'h0080_7E7F);
    fire();
    chk("R9 e4m3 nan", slot(2, 0), 32'h7FC00000);
    chk("R1 e4m3 448", slot(2, 1), 32'h43E00000);
    chk("R9 e4m3 -0", slot(2, 2), 32'h80000000);
  endtask

  task automatic t_fp6();
    scl_vec = {128{8'd127}};
    put_all(3'd3, 3'b100, {6'h1F, 84'd0, 6'h01});
    fire();
    chk("R1 e2m3 subnormal", slot(3, 0), 32'h3E000000);
    chk("R1 e2m3 slot15", slot(3, 15), 32'h40F00000);
    put_all(3'd4, 3'b100, {84'd0, 6'h21, 6'h1F});
    fire();
    chk("R1 e3m2 28", slot(3, 0), 32'h41E00000);
    chk("R1 e3m2 neg subnormal", slot(3, 1), 32'hBD800000);
  endtask

  task automatic t_half();
    scl_vec = {128{8'd127}};
    set_sc(0, 0, 8'd127); set_sc(1, 0, 8'd143);
    set_sc(2, 0, 8'd112); set_sc(3, 0, 8'd103);
    put_all(3'd1, 3'd1, 96'hFE3E_7E38);
    fire();
    chk("R8 f16 1.0", slot(0, 0), 32'h3C00);
    chk("R2 f16 448", slot(0, 1), 32'h5F00);
    chk("R2 f16 -448", slot(0, 3), 32'hDF00);
    chk("R10 f16 overflow", slot(1, 0), 32'h7C00);
    chk("R10 f16 -overflow", slot(1, 3), 32'hFC00);
    chk("R11 f16 subnormal", slot(2, 0), 32'h0200);
    chk("R11 f16 subnormal 1.75", slot(2, 2), 32'h0380);
    chk("R8 f16 scaled down", slot(2, 1), 32'h2300);
    chk("R11 f16 truncate 1.75", slot(3, 2), 32'h0001);
    chk("R11 f16 tiny 1.0", slot(3, 0), 32'h0001);
    chk("R11 f16 448 subnormal", slot(3, 1), 32'h01C0);
  endtask

  task automatic t_bf16();
    scl_vec = {128{8'd127}};
    set_sc(1, 0, 8'd254); set_sc(2, 0, 8'd1);
    put_all(3'd1, 3'd2, 96'h3E_7E38);
    fire();
    chk("R2 bf16 1.0", slot(0, 0), 32'h3F80);
    chk("R2 bf16 448", slot(0, 1), 32'h43E0);
    chk("R10 bf16 overflow", slot(1, 1), 32'h7F80);
    chk("R8 bf16 max scale", slot(1, 0), 32'h7F00);
    chk("R8 bf16 min scale", slot(2, 2), 32'h00E0);
    put_all(3'd1, 3'd0, 96'h7E);
    fire();
    chk("R10 f32 overflow", slot(1, 0), 32'h7F800000);
  endtask

  task automatic t_nanscale();
    scl_vec = {128{8'd127}};
    set_sc(4, 0, 8'hFF);
    put_all(3'd1, 3'd0, 96'h0000_0000_3800_0038);
    fire();
    for (int k = 0; k < 8; k++) chk("R8 nan scale f32", slot(4, k), 32'h7FC00000);
    chk("R8 neighbour lane", slot(5, 0), 32'h3F800000);
    put(4, 3'd1, 3'd1, 96'h38);
    fire();
    chk("R8 nan scale f16", slot(4, 0), 32'h7E00);
  endtask

  task automatic t_hold();
    scl_vec = {128{8'd127}};
    put_all(3'd1, 3'd0, 96'h38);
    fire();
    put_all(3'd1, 3'd0, 96'h40);
    @(negedge clk);
    @(negedge clk);
    chk("R12 data held without strobe", slot(0, 0), 32'h3F800000);
    chk("R12 no strobe", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog got=hung exp=done");
    finish_run();
  end

  initial begin
    put_all(3'd1, 3'd0, 96'h0);
    scl_vec = {128{8'd127}};
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_select(6'd32, 1'b0, 2'd0);
    t_select(6'd32, 1'b1, 2'd2);
    t_select(6'd16, 1'b0, 2'd1);
    t_select(6'd16, 1'b1, 2'd0);
    cfg(6'd32, 1'b0, 2'd0);
    t_illegal(6'd32, 2'd1);
    t_illegal(6'd16, 2'd2);
    t_illegal(6'd16, 2'd3);
    t_illegal(6'd24, 2'd0);
    t_mismatch();
    t_fp4();
    t_fp8();
    t_fp6();
    t_half();
    t_bf16();
    t_nanscale();
    t_hold();
    finish_run();
  end
endmodule